// File: doc/BRIEF.md
# Serial-Commanded Motor Bridge Controller

This block receives motor commands over a two-wire serial link (a clock line and an open-drain data line) and turns them into switch enables for one DC motor H-bridge and into sink controls for the phase windings of two stepper motors. Both serial lines are sampled by the system clock. A command frame has three bytes: a device address, a DC control byte and a stepper control byte. Each byte is sent most significant bit first, and the block acknowledges each byte it accepts by pulling the data line low for the ninth clock.

New settings take effect only when a complete and fully acknowledged frame is closed by a stop condition. The stored DC direction bits are combined with an external PWM input to set the four half-bridge switches. The stored stepper bits are combined with two shared PWM inputs, one for the A pair of windings and one for the B pair, to set the active-low phase outputs.

Top module: `motor_cmd_bridge`

## Requirements
- R1: With the clock line high, a falling data line is a start and a rising data line is a stop. Data changes while the clock is low are bit values. A full frame changes no output until its stop has been seen.
- R2: After the eighth bit of the address byte, when that byte equals DEV_ADDR (default 0x5A), and after the eighth bit of each of the two data bytes, `sda_drive_low` is high during the ninth clock. At all other times, including idle, it is low.
- R3: An address byte that differs from DEV_ADDR gets no acknowledge, and the rest of that frame changes nothing.
- R4: The stored settings update only at a stop that follows three acknowledged bytes. A frame stopped after fewer bytes is discarded.
- R5: A start received in the middle of a frame discards the partial frame and begins a new one.
- R6: A frame that carries a fourth byte before its stop is discarded.
- R7: DC bits `{dca,dcb}` = data byte 1 bits [1:0]. With 00, both low-side switches are on and both high-side switches are off, at any PWM level.
- R8: With DC bits 11, or with 01 or 10 while `dc_pwm` is low, both high-side switches are on and both low-side switches are off.
- R9: With DC bits 01 and `dc_pwm` high, the A low-side and B high-side switches are on and the other two are off.
- R10: With DC bits 10 and `dc_pwm` high, the A high-side and B low-side switches are on and the other two are off.
- R11: Stepper motor k takes data byte 2 bits [4k+3:4k] = {b_dir, b_en, a_dir, a_en}. Output bit 4k is A, 4k+1 is nA, 4k+2 is B and 4k+3 is nB, and 0 means the phase sinks current. A sinks when a_en=1, a_dir=0 and `stp_pwm_a`=1. nA sinks under the same conditions with a_dir=1. B and nB follow the same rule with b_en, b_dir and `stp_pwm_b`. A and nA never sink together, and B and nB never sink together.
- R12: The high-side and low-side enables of one half-bridge are never both high in the same cycle.
- R13: After reset the DC bits are 00 (both low sides on), every stepper phase output is 1, and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired) |
| sda_drive_low | output | 1 | 1 pulls the data line low (acknowledge) |
| dc_pwm | input | 1 | PWM for the DC bridge |
| stp_pwm_a | input | 1 | PWM shared by the A/nA windings |
| stp_pwm_b | input | 1 | PWM shared by the B/nB windings |
| hb_a_hi | output | 1 | Half-bridge A high-side enable |
| hb_a_lo | output | 1 | Half-bridge A low-side enable |
| hb_b_hi | output | 1 | Half-bridge B high-side enable |
| hb_b_lo | output | 1 | Half-bridge B low-side enable |
| step_ph_n | output | 4*STEP_COUNT | Active-low stepper phase sinks |

## Verification
Two functions can act in the same cycle: a commit at a stop, and a PWM-driven change of the bridge decode. Both write the same output registers. The bench holds each PWM level fixed while a frame commits and then sweeps the PWM inputs. It compares every switch and phase output with values it computes from the stored command bits. Frames that must be rejected are sent on top of a known stored setting, and the bench checks that the outputs keep that setting.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_ACK,
        RX_HOLD,
        RX_SKIP
    } rx_state_t;

    typedef struct packed {
        logic a_hi;
        logic a_lo;
        logic b_hi;
        logic b_lo;
    } hb_en_t;

    localparam hb_en_t HB_BRAKE_LOW  = '{a_hi: 1'b0, a_lo: 1'b1, b_hi: 1'b0, b_lo: 1'b1};
    localparam hb_en_t HB_BRAKE_HIGH = '{a_hi: 1'b1, a_lo: 1'b0, b_hi: 1'b1, b_lo: 1'b0};

    function automatic hb_en_t dc_decode(input logic [1:0] dc, input logic pwm);
        hb_en_t r;
        case (dc)
            2'b00:   r = HB_BRAKE_LOW;
            2'b01:   r = pwm ? '{a_hi: 1'b0, a_lo: 1'b1, b_hi: 1'b1, b_lo: 1'b0} : HB_BRAKE_HIGH;
            2'b10:   r = pwm ? '{a_hi: 1'b1, a_lo: 1'b0, b_hi: 1'b0, b_lo: 1'b1} : HB_BRAKE_HIGH;
            default: r = HB_BRAKE_HIGH;
        endcase
        return r;
    endfunction

    // cfg = {b_dir, b_en, a_dir, a_en}; result = active-high sinks {nB, B, nA, A}
    function automatic logic [3:0] step_sink(input logic [3:0] cfg, input logic pa, input logic pb);
        logic a_on;
        logic b_on;
        a_on = cfg[0] & pa;
        b_on = cfg[2] & pb;
        return {b_on & cfg[3], b_on & ~cfg[3], a_on & cfg[1], a_on & ~cfg[1]};
    endfunction

endpackage

// File: rtl/mcb_line_sync.sv
module mcb_line_sync #(
    parameter int          N           = 1,
    parameter int          SYNC_STAGES = 2,
    parameter logic [N-1:0] RST_VAL    = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl
);
    logic [N-1:0] stg [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign lvl = stg[SYNC_STAGES-1];
endmodule

// File: rtl/mcb_frame_rx.sv
module mcb_frame_rx
    import mcb_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'h5A,
    parameter int         STEP_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_pull,
    output logic              commit,
    output logic [1:0]        dc_bits,
    output logic [STEP_W-1:0] step_bits
);
    rx_state_t         state;
    logic [3:0]        bit_cnt;
    logic [1:0]        byte_idx;
    logic [7:0]        shreg;
    logic [1:0]        dc_stage;
    logic [STEP_W-1:0] step_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            bit_cnt    <= '0;
            byte_idx   <= '0;
            shreg      <= '0;
            sda_pull   <= 1'b0;
            commit     <= 1'b0;
            dc_stage   <= '0;
            step_stage <= '0;
            dc_bits    <= '0;
            step_bits  <= '0;
        end else begin
            commit <= 1'b0;
            if (start_det) begin
                state    <= RX_SHIFT;
                bit_cnt  <= '0;
                byte_idx <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                if (state == RX_HOLD) begin
                    commit    <= 1'b1;
                    dc_bits   <= dc_stage;
                    step_bits <= step_stage;
                end
                state    <= RX_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    RX_SHIFT: begin
                        if (scl_rise && bit_cnt != 4'd8) begin
                            shreg   <= {shreg[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (byte_idx == 2'd0 && shreg != DEV_ADDR) begin
                                state <= RX_SKIP;
                            end else begin
                                sda_pull <= 1'b1;
                                state    <= RX_ACK;
                                if (byte_idx == 2'd1) dc_stage   <= shreg[1:0];
                                if (byte_idx == 2'd2) step_stage <= shreg[STEP_W-1:0];
                            end
                        end
                    end
                    RX_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            if (byte_idx == 2'd2) begin
                                state <= RX_HOLD;
                            end else begin
                                byte_idx <= byte_idx + 2'd1;
                                state    <= RX_SHIFT;
                            end
                        end
                    end
                    RX_HOLD: begin
                        if (scl_fall) state <= RX_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ACK_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_lvl);                                   // R2
    AST_NO_ACK_AFTER_SKIP: assert property (@(posedge clk) disable iff (rst)
        (state == RX_SKIP && !start_det) |=> !$rose(sda_pull));          // R3
endmodule

// File: rtl/mcb_bridge_decode.sv
module mcb_bridge_decode
    import mcb_pkg::*;
#(
    parameter int STEP_COUNT = 2,
    localparam int STEP_W    = 4 * STEP_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        dc_bits,
    input  logic [STEP_W-1:0] step_bits,
    input  logic              pwm_dc,
    input  logic              pwm_a,
    input  logic              pwm_b,
    output hb_en_t            hb,
    output logic [STEP_W-1:0] step_ph_n
);
    always_ff @(posedge clk) begin
        if (rst) hb <= HB_BRAKE_LOW;
        else     hb <= dc_decode(dc_bits, pwm_dc);
    end

    generate
        for (genvar k = 0; k < STEP_COUNT; k++) begin : g_motor
            always_ff @(posedge clk) begin
                if (rst) step_ph_n[4*k +: 4] <= '1;
                else     step_ph_n[4*k +: 4] <= ~step_sink(step_bits[4*k +: 4], pwm_a, pwm_b);
            end

            AST_PAIR_A_EXCL: assert property (@(posedge clk) disable iff (rst)
                step_ph_n[4*k] || step_ph_n[4*k+1]);                      // R11
            AST_PAIR_B_EXCL: assert property (@(posedge clk) disable iff (rst)
                step_ph_n[4*k+2] || step_ph_n[4*k+3]);                    // R11
        end
    endgenerate

    AST_A_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
        !(hb.a_hi && hb.a_lo));                                           // R12
    AST_B_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
        !(hb.b_hi && hb.b_lo));                                           // R12
    AST_DC_BRAKE_LOW: assert property (@(posedge clk) disable iff (rst)
        (dc_bits == 2'b00) |=> (hb.a_lo && hb.b_lo && !hb.a_hi && !hb.b_hi)); // R7
    AST_DC_HIGH_IDLE: assert property (@(posedge clk) disable iff (rst)
        (dc_bits == 2'b11 || (dc_bits != 2'b00 && !pwm_dc)) |=> (hb.a_hi && hb.b_hi)); // R8
    AST_DC_FWD: assert property (@(posedge clk) disable iff (rst)
        (dc_bits == 2'b01 && pwm_dc) |=> (hb.a_lo && hb.b_hi));           // R9
    AST_DC_REV: assert property (@(posedge clk) disable iff (rst)
        (dc_bits == 2'b10 && pwm_dc) |=> (hb.a_hi && hb.b_lo));           // R10
endmodule

// File: rtl/motor_cmd_bridge.sv
module motor_cmd_bridge
    import mcb_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR    = 8'h5A,
    parameter int         STEP_COUNT  = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_in,
    input  logic                    sda_in,
    output logic                    sda_drive_low,
    input  logic                    dc_pwm,
    input  logic                    stp_pwm_a,
    input  logic                    stp_pwm_b,
    output logic                    hb_a_hi,
    output logic                    hb_a_lo,
    output logic                    hb_b_hi,
    output logic                    hb_b_lo,
    output logic [4*STEP_COUNT-1:0] step_ph_n
);
    localparam int STEP_W = 4 * STEP_COUNT;

    logic [1:0]        ser_lvl;
    logic [2:0]        pwm_lvl;
    logic              scl_d, sda_d;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic              commit;
    logic [1:0]        dc_bits;
    logic [STEP_W-1:0] step_bits;
    hb_en_t            hb;

    mcb_line_sync #(.N(2), .SYNC_STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_ser_sync (
        .clk(clk), .rst(rst), .raw({scl_in, sda_in}), .lvl(ser_lvl));

    mcb_line_sync #(.N(3), .SYNC_STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_pwm_sync (
        .clk(clk), .rst(rst), .raw({dc_pwm, stp_pwm_a, stp_pwm_b}), .lvl(pwm_lvl));

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= ser_lvl[1];
            sda_d <= ser_lvl[0];
        end
    end

    assign scl_rise  =  ser_lvl[1] & ~scl_d;
    assign scl_fall  = ~ser_lvl[1] &  scl_d;
    assign start_det =  ser_lvl[1] &  scl_d &  sda_d & ~ser_lvl[0];
    assign stop_det  =  ser_lvl[1] &  scl_d & ~sda_d &  ser_lvl[0];

    mcb_frame_rx #(.DEV_ADDR(DEV_ADDR), .STEP_W(STEP_W)) u_rx (
        .clk(clk), .rst(rst),
        .scl_lvl(ser_lvl[1]), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(ser_lvl[0]), .start_det(start_det), .stop_det(stop_det),
        .sda_pull(sda_drive_low), .commit(commit),
        .dc_bits(dc_bits), .step_bits(step_bits));

    mcb_bridge_decode #(.STEP_COUNT(STEP_COUNT)) u_dec (
        .clk(clk), .rst(rst),
        .dc_bits(dc_bits), .step_bits(step_bits),
        .pwm_dc(pwm_lvl[2]), .pwm_a(pwm_lvl[1]), .pwm_b(pwm_lvl[0]),
        .hb(hb), .step_ph_n(step_ph_n));

    assign hb_a_hi = hb.a_hi;
    assign hb_a_lo = hb.a_lo;
    assign hb_b_hi = hb.b_hi;
    assign hb_b_lo = hb.b_lo;

    AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(stop_det));                                      // R4
    AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |-> $stable(dc_bits) && $stable(step_bits));              // R4
endmodule

// File: tb/motor_cmd_bridge_bench.sv
module motor_cmd_bridge_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       dc_pwm = 1'b0, pwm_a = 1'b0, pwm_b = 1'b0;
    logic       sda_drive_low;
    logic       hb_a_hi, hb_a_lo, hb_b_hi, hb_b_lo;
    logic [7:0] step_ph_n;
    logic       sda;
    int         n_chk = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz
    assign sda = ~(m_low | sda_drive_low);

    motor_cmd_bridge u_motor_cmd_bridge (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .sda_drive_low(sda_drive_low),
        .dc_pwm(dc_pwm), .stp_pwm_a(pwm_a), .stp_pwm_b(pwm_b),
        .hb_a_hi(hb_a_hi), .hb_a_lo(hb_a_lo), .hb_b_hi(hb_b_hi), .hb_b_lo(hb_b_lo),
        .step_ph_n(step_ph_n));

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_dc(input logic [1:0] dc, input logic p);
        if (dc == 2'b00)               return 4'b0101;   // {a_hi,a_lo,b_hi,b_lo}
        else if (dc == 2'b11 || !p)    return 4'b1010;
        else if (dc == 2'b01)          return 4'b0110;
        else                           return 4'b1001;
    endfunction

    function automatic logic [7:0] exp_step(input logic [7:0] cfg, input logic pa, input logic pb);
        logic [7:0] r;
        r = 8'hFF;
        for (int k = 0; k < 2; k++) begin
            if (cfg[4*k] && pa)   r[4*k + (cfg[4*k+1] ? 1 : 0)] = 1'b0;
            if (cfg[4*k+2] && pb) r[4*k + 2 + (cfg[4*k+3] ? 1 : 0)] = 1'b0;
        end
        return r;
    endfunction

    task automatic bus_start();
        m_low = 1'b0; scl = 1'b1; hold(8);
        m_low = 1'b1; hold(8);
        scl = 1'b0; hold(4);
    endtask

    task automatic bus_restart();
        m_low = 1'b0; hold(4);
        scl = 1'b1; hold(8);
        m_low = 1'b1; hold(8);
        scl = 1'b0; hold(4);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; hold(4);
        scl = 1'b1; hold(8);
        m_low = 1'b0; hold(12);
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; hold(4);
        scl = 1'b1; hold(8);
        scl = 1'b0; hold(4);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        m_low = 1'b0; hold(4);
        scl = 1'b1; hold(4);
        ack = (sda == 1'b0);
        hold(4);
        scl = 1'b0; hold(4);
    endtask

    task automatic frame(input logic [7:0] d1, input logic [7:0] d2);
        logic ack;
        bus_start();
        send_byte(8'h5A, ack); chk("R2 address ack", ack, 1'b1);
        send_byte(d1, ack);    chk("R2 data1 ack", ack, 1'b1);
        send_byte(d2, ack);    chk("R2 data2 ack", ack, 1'b1);
        bus_stop();
    endtask

    task automatic check_dc(input string tag, input logic [1:0] dc);
        for (int p = 0; p < 2; p++) begin
            dc_pwm = p[0]; hold(6);
            chk(tag, {hb_a_hi, hb_a_lo, hb_b_hi, hb_b_lo}, exp_dc(dc, p[0]));
            chk("R12 no shoot-through", {hb_a_hi & hb_a_lo, hb_b_hi & hb_b_lo}, 2'b00);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        hold(5);
        rst = 1'b0;
        hold(5);
        // R13 reset state
        chk("R13 bridge reset", {hb_a_hi, hb_a_lo, hb_b_hi, hb_b_lo}, 4'b0101);
        chk("R13 phases reset", step_ph_n, 8'hFF);
        chk("R13 line released", sda_drive_low, 1'b0);

        // R7 R8 R9 R10: every DC code under both PWM levels
        for (int dc = 0; dc < 4; dc++) begin
            frame(8'(dc), 8'h00);
            if (dc == 0)      check_dc("R7 dc 00", 2'(dc));
            else if (dc == 1) check_dc("R9 dc 01", 2'(dc));
            else if (dc == 2) check_dc("R10 dc 10", 2'(dc));
            else              check_dc("R8 dc 11", 2'(dc));
        end

        // R11: stepper sweep, motor1 gets the complement pattern
        for (int v = 0; v < 16; v++) begin
            logic [7:0] cfg;
            cfg = 8'(v) | (8'(15 - v) << 4);
            frame(8'h02, cfg);
            for (int pw = 0; pw < 4; pw++) begin
                pwm_a = pw[0]; pwm_b = pw[1]; hold(6);
                chk("R11 stepper phases", step_ph_n, exp_step(cfg, pw[0], pw[1]));
            end
        end
        pwm_a = 1'b1; pwm_b = 1'b1; dc_pwm = 1'b1;
        frame(8'h01, 8'h15);   // known setting: dc 01, cfg 0x15
        hold(6);
        chk("R9 known setting", {hb_a_hi, hb_a_lo, hb_b_hi, hb_b_lo}, exp_dc(2'b01, 1'b1));
        chk("R2 idle released", sda_drive_low, 1'b0);

        // R1: outputs unchanged until the stop of a full frame
        bus_start();
        send_byte(8'h5A, ack); send_byte(8'h02, ack); send_byte(8'h8A, ack);
        hold(10);
        chk("R1 no change before stop", step_ph_n, exp_step(8'h15, 1'b1, 1'b1));
        bus_stop(); hold(4);
        chk("R1 change after stop", step_ph_n, exp_step(8'h8A, 1'b1, 1'b1));
        chk("R1 dc after stop", {hb_a_hi, hb_a_lo, hb_b_hi, hb_b_lo}, exp_dc(2'b10, 1'b1));

        // R3: wrong address
        bus_start();
        send_byte(8'h5B, ack); chk("R3 no address ack", ack, 1'b0);
        send_byte(8'h03, ack); chk("R3 no data ack", ack, 1'b0);
        send_byte(8'hFF, ack);
        bus_stop(); hold(4);
        chk("R3 phases unchanged", step_ph_n, exp_step(8'h8A, 1'b1, 1'b1));
        chk("R3 dc unchanged", {hb_a_hi, hb_a_lo, hb_b_hi, hb_b_lo}, exp_dc(2'b10, 1'b1));

        // R4: partial frame
        bus_start();
        send_byte(8'h5A, ack); send_byte(8'h03, ack);
        bus_stop(); hold(4);
        chk("R4 partial discarded", {hb_a_hi, hb_a_lo, hb_b_hi, hb_b_lo}, exp_dc(2'b10, 1'b1));
        chk("R4 phases kept", step_ph_n, exp_step(8'h8A, 1'b1, 1'b1));

        // R6: four bytes
        bus_start();
        send_byte(8'h5A, ack); send_byte(8'h00, ack); send_byte(8'h44, ack); send_byte(8'h00, ack);
        bus_stop(); hold(4);
        chk("R6 long frame discarded", {hb_a_hi, hb_a_lo, hb_b_hi, hb_b_lo}, exp_dc(2'b10, 1'b1));
        chk("R6 phases kept", step_ph_n, exp_step(8'h8A, 1'b1, 1'b1));

        // R5: repeated start mid-byte
        bus_start();
        send_byte(8'h5A, ack);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_restart();
        send_byte(8'h5A, ack); chk("R5 ack after restart", ack, 1'b1);
        send_byte(8'h00, ack); send_byte(8'h54, ack);
        bus_stop(); hold(4);
        chk("R5 new frame applied", {hb_a_hi, hb_a_lo, hb_b_hi, hb_b_lo}, exp_dc(2'b00, 1'b1));
        chk("R5 phases applied", step_ph_n, exp_step(8'h54, 1'b1, 1'b1));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule